// File: doc/BRIEF.md
# Real-Time Clock Counter and Alarm Core

This core holds a wall-clock time and calendar: seconds, minutes, hours, day of week, day of month, month and a two-digit year. Once per second, when an external one-second mark arrives on a reference tick, the core advances these counters. Every field can be held in packed BCD or in plain binary. Hours can run in 24-hour form or in 12-hour form, where bit 7 of the hours byte marks PM. Before each advance the core raises an update-in-progress status for a fixed number of reference ticks. It keeps that status up through a configurable update window, so software knows when a read could be torn. Each advance gives a one-cycle update-done event. When the new seconds, minutes and hours match three alarm bytes, it also gives an alarm event.

A byte-wide register port gives access to all fields at fixed addresses. Requests use a valid/ready handshake. `req_ready` is always high, so every request is taken in the cycle it is presented and there is no back-pressure. A read answers one cycle later with `rsp_valid`. The response path has no ready signal and the requester must accept it. A control byte at address 11 selects the data mode and the hour format. It also holds a freeze bit that stops all advancing while software loads a new time.

Top module: `rtc_time_core`

## Requirements
- R1: After reset, time fields read sec=0x00, min=0x00, hour=0x00, day-of-week=0x01, day-of-month=0x01, month=0x01, year=0x00. Control (address 11) reads 0x02, status (address 10) reads 0x00, and `uip` is low.
- R2: The address map is 0 sec, 1 sec alarm, 2 min, 3 min alarm, 4 hour, 5 hour alarm, 6 day of week, 7 day of month, 8 month, 9 year, 10 status (bit 7 = update in progress, read-only), 11 control. Addresses 12..15 read 0x00. A read accepted in one cycle gives `rsp_valid` high with the data in the next cycle, and only then. A write stores the byte unchanged.
- R3: Control bit 2 set selects binary and clear selects BCD. Seconds and minutes wrap from 59 to 0 and carry. In 24-hour mode (control bit 1 set), hours wrap from 23 to 0 and carry into the date.
- R4: With control bit 1 clear, hours hold 1..12 in bits 6:0 and PM in bit 7. 11 AM advances to 12 PM. 12 PM advances to 1 PM. 11 PM advances to 12 AM and carries into the date.
- R5: On a day carry, day of month wraps to 1 after the month's last day. April, June, September and November have 30 days. February has 29 days when the year is a multiple of 4 and 28 otherwise. The other months have 31 days. Month wraps from 12 to 1 and carries into the year. Year wraps from 99 to 0.
- R6: On a day carry, day of week advances 1..7 and wraps from 7 to 1.
- R7: A `sec_mark` seen on a `ref_tick` raises `uip` in the next cycle. The counters change at the LEAD_TICKS-th following reference tick. `uip` clears UPD_TICKS reference ticks after that. With the defaults and a tick every cycle, `uip` stays high for 16 cycles.
- R8: `upd_done` is high for exactly one cycle, the first cycle in which the advanced values can be read.
- R9: While control bit 7 (freeze) is set, `sec_mark` is ignored, `uip` is low, no advance happens and `upd_done` stays low.
- R10: `alarm_hit` pulses with `upd_done` when the advanced seconds, minutes and hours each equal their alarm byte.
- R11: An alarm byte with bits 7 and 6 both set matches any value. An alarm byte with only bit 7 set compares normally.
- R12: A register write in the same cycle as an advance wins for the written field. All other fields still take their advanced values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle enable per reference clock period |
| sec_mark | input | 1 | Start of a new second; sampled on `ref_tick` |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request ready (always high) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 8 | Read data |
| uip | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle pulse after an advance |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
A register write and the once-per-second advance can fall in the same cycle. The bench provokes this by counting reference ticks from the second mark and timing a seconds write to land on the tick that ends the lead phase. The check is that seconds hold the written byte while minutes still show the carry from the old 59 seconds. The alarm event also coincides with the update-done pulse. It is judged by sampling both outputs in the same cycle for matching, partly masked and non-matching alarm bytes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 4;

  typedef struct packed {
    logic [BYTE_W-1:0] sec;
    logic [BYTE_W-1:0] min;
    logic [BYTE_W-1:0] hr;
    logic [BYTE_W-1:0] dow;
    logic [BYTE_W-1:0] dom;
    logic [BYTE_W-1:0] mon;
    logic [BYTE_W-1:0] yr;
  } rtc_time_t;

  typedef enum logic [ADDR_W-1:0] {
    A_SEC = 4'd0, A_ASEC = 4'd1, A_MIN = 4'd2, A_AMIN = 4'd3,
    A_HR = 4'd4, A_AHR = 4'd5, A_DOW = 4'd6, A_DOM = 4'd7,
    A_MON = 4'd8, A_YR = 4'd9, A_STAT = 4'd10, A_CTRL = 4'd11
  } rtc_addr_e;

  // control byte bit positions
  localparam int C_FREEZE = 7;
  localparam int C_BIN    = 2;
  localparam int C_H24    = 1;

  function automatic logic [6:0] to_bin(input logic [7:0] v, input logic bin);
    if (bin) return v[6:0];
    return 7'({3'b000, v[7:4]}) * 7'd10 + 7'({3'b000, v[3:0]});
  endfunction

  function automatic logic [7:0] from_bin(input logic [6:0] b, input logic bin);
    logic [6:0] tens;
    logic [6:0] ones;
    if (bin) return {1'b0, b};
    tens = b / 7'd10;
    ones = b - tens * 7'd10;
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic logic [6:0] days_in(input logic [6:0] mon, input logic leap);
    case (mon)
      7'd2:                       return leap ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:    return 7'd30;
      default:                    return 7'd31;
    endcase
  endfunction

endpackage

// File: rtl/rtc_upd_seq.sv
module rtc_upd_seq #(
  parameter int LEAD_TICKS = 8,
  parameter int UPD_TICKS  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic sec_mark,
  input  logic hold,
  output logic uip,
  output logic upd_go
);
  localparam int MAXT = (LEAD_TICKS > UPD_TICKS) ? LEAD_TICKS : UPD_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_HOLD} seq_st_e;

  seq_st_e        st_q;
  logic [CW-1:0]  cnt_q;
  logic           cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else if (hold) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else if (ref_tick) begin
      case (st_q)
        S_IDLE: if (sec_mark) begin
          st_q  <= S_LEAD;
          cnt_q <= CW'(LEAD_TICKS - 1);
        end
        S_LEAD: if (cnt_zero) begin
          st_q  <= S_HOLD;
          cnt_q <= CW'(UPD_TICKS - 1);
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        S_HOLD: if (cnt_zero) begin
          st_q <= S_IDLE;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign uip    = (st_q != S_IDLE);
  assign upd_go = ref_tick & ~hold & (st_q == S_LEAD) & cnt_zero;

endmodule

// File: rtl/rtc_time_next.sv
module rtc_time_next
  import rtc_pkg::*;
(
  input  rtc_time_t cur,
  input  logic      bin_mode,
  input  logic      h24_mode,
  output rtc_time_t nxt
);
  logic [6:0] s_b, m_b, h_b, h24, h24n, h12n, dw_b, dd_b, mo_b, yr_b;
  logic       c_s, c_m, c_h, c_d, c_mo;

  always_comb begin
    s_b  = to_bin(cur.sec, bin_mode);
    m_b  = to_bin(cur.min, bin_mode);
    h_b  = to_bin({1'b0, cur.hr[6:0]}, bin_mode);
    dw_b = to_bin(cur.dow, bin_mode);
    dd_b = to_bin(cur.dom, bin_mode);
    mo_b = to_bin(cur.mon, bin_mode);
    yr_b = to_bin(cur.yr, bin_mode);

    // hours onto a 0..23 scale
    if (h24_mode)        h24 = h_b;
    else if (h_b == 7'd12) h24 = cur.hr[7] ? 7'd12 : 7'd0;
    else                 h24 = cur.hr[7] ? h_b + 7'd12 : h_b;

    nxt  = cur;
    h24n = h24;
    h12n = 7'd12;
    c_m  = 1'b0;
    c_h  = 1'b0;
    c_d  = 1'b0;
    c_mo = 1'b0;

    c_s     = (s_b >= 7'd59);
    nxt.sec = c_s ? 8'h00 : from_bin(s_b + 7'd1, bin_mode);

    if (c_s) begin
      c_m     = (m_b >= 7'd59);
      nxt.min = c_m ? 8'h00 : from_bin(m_b + 7'd1, bin_mode);
    end

    if (c_m) begin
      c_h  = (h24 >= 7'd23);
      h24n = c_h ? 7'd0 : h24 + 7'd1;
      h12n = (h24n >= 7'd12) ? h24n - 7'd12 : h24n;
      if (h12n == 7'd0) h12n = 7'd12;
      if (h24_mode) nxt.hr = from_bin(h24n, bin_mode);
      else          nxt.hr = {(h24n >= 7'd12), from_bin(h12n, bin_mode)[6:0]};
    end

    if (c_h) begin
      nxt.dow = (dw_b >= 7'd7) ? 8'h01 : from_bin(dw_b + 7'd1, bin_mode);
      c_d     = (dd_b >= days_in(mo_b, (yr_b[1:0] == 2'b00)));
      nxt.dom = c_d ? 8'h01 : from_bin(dd_b + 7'd1, bin_mode);
    end

    if (c_d) begin
      c_mo    = (mo_b >= 7'd12);
      nxt.mon = c_mo ? 8'h01 : from_bin(mo_b + 7'd1, bin_mode);
    end

    if (c_mo) begin
      nxt.yr = (yr_b >= 7'd99) ? 8'h00 : from_bin(yr_b + 7'd1, bin_mode);
    end
  end

endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp #(
  parameter int NFIELDS = 3
) (
  input  logic [NFIELDS-1:0][7:0] value,
  input  logic [NFIELDS-1:0][7:0] alarm,
  output logic                    match
);
  logic [NFIELDS-1:0] hit;

  for (genvar g = 0; g < NFIELDS; g++) begin : g_fld
    assign hit[g] = (alarm[g][7:6] == 2'b11) || (alarm[g] == value[g]);
  end

  assign match = &hit;

endmodule

// File: rtl/rtc_time_core.sv
module rtc_time_core
  import rtc_pkg::*;
#(
  parameter int LEAD_TICKS = 8,
  parameter int UPD_TICKS  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ref_tick,
  input  logic                sec_mark,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_we,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [BYTE_W-1:0]   req_wdata,
  output logic                rsp_valid,
  output logic [BYTE_W-1:0]   rsp_data,
  output logic                uip,
  output logic                upd_done,
  output logic                alarm_hit
);
  rtc_time_t         time_q, time_nxt;
  logic [BYTE_W-1:0] al_sec_q, al_min_q, al_hr_q, ctrl_q;
  logic              upd_go, al_match, wr_en, rd_en;
  logic [BYTE_W-1:0] rd_mux;

  assign req_ready = 1'b1;
  assign wr_en     = req_valid & req_we;
  assign rd_en     = req_valid & ~req_we;

  rtc_upd_seq #(.LEAD_TICKS(LEAD_TICKS), .UPD_TICKS(UPD_TICKS)) u_seq (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sec_mark(sec_mark),
    .hold(ctrl_q[C_FREEZE]), .uip(uip), .upd_go(upd_go)
  );

  rtc_time_next u_next (
    .cur(time_q), .bin_mode(ctrl_q[C_BIN]), .h24_mode(ctrl_q[C_H24]),
    .nxt(time_nxt)
  );

  rtc_alarm_cmp #(.NFIELDS(3)) u_alarm (
    .value({time_nxt.hr, time_nxt.min, time_nxt.sec}),
    .alarm({al_hr_q, al_min_q, al_sec_q}),
    .match(al_match)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q    <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, dow: 8'h01,
                     dom: 8'h01, mon: 8'h01, yr: 8'h00};
      al_sec_q  <= '0;
      al_min_q  <= '0;
      al_hr_q   <= '0;
      ctrl_q    <= 8'h02;
      upd_done  <= 1'b0;
      alarm_hit <= 1'b0;
    end else begin
      if (upd_go) time_q <= time_nxt;
      // a write in the advance cycle overrides its own field only
      if (wr_en) begin
        case (req_addr)
          A_SEC:  time_q.sec <= req_wdata;
          A_ASEC: al_sec_q   <= req_wdata;
          A_MIN:  time_q.min <= req_wdata;
          A_AMIN: al_min_q   <= req_wdata;
          A_HR:   time_q.hr  <= req_wdata;
          A_AHR:  al_hr_q    <= req_wdata;
          A_DOW:  time_q.dow <= req_wdata;
          A_DOM:  time_q.dom <= req_wdata;
          A_MON:  time_q.mon <= req_wdata;
          A_YR:   time_q.yr  <= req_wdata;
          A_CTRL: ctrl_q     <= req_wdata;
          default: ;
        endcase
      end
      upd_done  <= upd_go;
      alarm_hit <= upd_go & al_match;
    end
  end

  always_comb begin
    case (req_addr)
      A_SEC:   rd_mux = time_q.sec;
      A_ASEC:  rd_mux = al_sec_q;
      A_MIN:   rd_mux = time_q.min;
      A_AMIN:  rd_mux = al_min_q;
      A_HR:    rd_mux = time_q.hr;
      A_AHR:   rd_mux = al_hr_q;
      A_DOW:   rd_mux = time_q.dow;
      A_DOM:   rd_mux = time_q.dom;
      A_MON:   rd_mux = time_q.mon;
      A_YR:    rd_mux = time_q.yr;
      A_STAT:  rd_mux = {uip, 7'b0};
      A_CTRL:  rd_mux = ctrl_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_data <= rd_mux;
    end
  end

endmodule

// File: rtl/rtc_time_core_chk.sv
module rtc_time_core_chk (
  input logic clk,
  input logic rst_n,
  input logic uip,
  input logic upd_done,
  input logic alarm_hit,
  input logic req_valid,
  input logic req_we,
  input logic rsp_valid,
  input logic freeze
);
  // R8
  upd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> !upd_done);

  // R10
  alarm_with_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> upd_done);

  // R7
  upd_inside_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |-> uip);

  // R9
  freeze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (!uip && !upd_done));

  // R2
  read_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_we) |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && !req_we) |=> !rsp_valid);
endmodule

bind rtc_time_core rtc_time_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .uip(uip), .upd_done(upd_done),
  .alarm_hit(alarm_hit), .req_valid(req_valid), .req_we(req_we),
  .rsp_valid(rsp_valid), .freeze(ctrl_q[7])
);

// File: tb/rtc_time_core_tb_top.sv
module rtc_time_core_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b1;
  logic       sec_mark = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_we = 1'b0;
  logic [3:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       req_ready, rsp_valid, uip, upd_done, alarm_hit;
  logic [7:0] rsp_data;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  rtc_time_core dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sec_mark(sec_mark),
    .req_valid(req_valid), .req_ready(req_ready), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .uip(uip), .upd_done(upd_done), .alarm_hit(alarm_hit)
  );

  // ctrl, sec, min, hr, dow, dom, mon, yr, then the seven expected bytes
  localparam int NV = 10;
  localparam logic [7:0] VEC [NV][15] = '{
    '{8'h02, 8'h59,8'h59,8'h23,8'h07,8'h31,8'h12,8'h99, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h01,8'h00},
    '{8'h02, 8'h56,8'h34,8'h12,8'h03,8'h15,8'h06,8'h21, 8'h57,8'h34,8'h12,8'h03,8'h15,8'h06,8'h21},
    '{8'h02, 8'h59,8'h59,8'h09,8'h02,8'h10,8'h05,8'h20, 8'h00,8'h00,8'h10,8'h02,8'h10,8'h05,8'h20},
    '{8'h06, 8'h3B,8'h3B,8'h17,8'h04,8'h1C,8'h02,8'h18, 8'h00,8'h00,8'h00,8'h05,8'h1D,8'h02,8'h18},
    '{8'h06, 8'h3B,8'h3B,8'h17,8'h07,8'h1C,8'h02,8'h17, 8'h00,8'h00,8'h00,8'h01,8'h01,8'h03,8'h17},
    '{8'h00, 8'h59,8'h59,8'h11,8'h01,8'h05,8'h04,8'h10, 8'h00,8'h00,8'h92,8'h01,8'h05,8'h04,8'h10},
    '{8'h00, 8'h59,8'h59,8'h91,8'h06,8'h30,8'h04,8'h10, 8'h00,8'h00,8'h12,8'h07,8'h01,8'h05,8'h10},
    '{8'h04, 8'h3B,8'h3B,8'h8C,8'h02,8'h0A,8'h03,8'h05, 8'h00,8'h00,8'h81,8'h02,8'h0A,8'h03,8'h05},
    '{8'h02, 8'h59,8'h59,8'h23,8'h05,8'h30,8'h09,8'h05, 8'h00,8'h00,8'h00,8'h06,8'h01,8'h10,8'h05},
    '{8'h02, 8'h59,8'h59,8'h23,8'h01,8'h29,8'h02,8'h24, 8'h00,8'h00,8'h00,8'h02,8'h01,8'h03,8'h24}
  };
  localparam logic [3:0] FADDR [7] = '{4'd0, 4'd2, 4'd4, 4'd6, 4'd7, 4'd8, 4'd9};

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    d = rsp_valid ? rsp_data : 8'hXX;
  endtask

  task automatic load(input logic [7:0] ctrl, input logic [7:0] f [7]);
    wr(4'd11, ctrl | 8'h80);
    for (int i = 0; i < 7; i++) wr(FADDR[i], f[i]);
    wr(4'd11, ctrl);
  endtask

  // one second: returns index of upd_done, length of uip, alarm seen
  task automatic second(output int done_idx, output int uip_len, output logic hit);
    done_idx = -1; uip_len = 0; hit = 1'b0;
    @(negedge clk); sec_mark = 1'b1;
    @(negedge clk); sec_mark = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (!uip) break;
      if (upd_done) begin done_idx = i; hit = alarm_hit; end
      uip_len++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d;
    logic [7:0] f [7];
    int di, ul;
    logic hit;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 uip", {7'b0, uip}, 8'h00);
    rd(4'd11, d); check("R1 ctrl", d, 8'h02);
    rd(4'd10, d); check("R1 status", d, 8'h00);
    rd(4'd0,  d); check("R1 sec", d, 8'h00);
    rd(4'd6,  d); check("R1 dow", d, 8'h01);
    rd(4'd7,  d); check("R1 dom", d, 8'h01);
    rd(4'd8,  d); check("R1 mon", d, 8'h01);

    // R2 map and response
    check("R2 ready", {7'b0, req_ready}, 8'h01);
    wr(4'd1, 8'h5A); rd(4'd1, d); check("R2 alarm rw", d, 8'h5A);
    rd(4'd13, d); check("R2 unmapped", d, 8'h00);
    wr(4'd1, 8'h00);

    // vector table: R3 R4 R5 R6
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < 7; i++) f[i] = VEC[v][1+i];
      load(VEC[v][0], f);
      second(di, ul, hit);
      for (int i = 0; i < 7; i++) begin
        rd(FADDR[i], d);
        if (i < 2)       check($sformatf("R3 vec%0d field%0d", v, i), d, VEC[v][8+i]);
        else if (i == 2) check($sformatf("%s vec%0d hour", VEC[v][0][1] ? "R3" : "R4", v), d, VEC[v][8+i]);
        else if (i == 3) check($sformatf("R6 vec%0d dow", v), d, VEC[v][8+i]);
        else             check($sformatf("R5 vec%0d field%0d", v, i), d, VEC[v][8+i]);
      end
    end

    // R7 R8 timing
    f = '{8'h10, 8'h10, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00};
    load(8'h02, f);
    second(di, ul, hit);
    check("R7 uip length", 8'(ul), 8'd16);
    check("R8 done index", 8'(di), 8'd8);
    rd(4'd10, d); check("R7 status idle", d, 8'h00);

    // R9 freeze
    wr(4'd11, 8'h82);
    @(negedge clk); sec_mark = 1'b1;
    @(negedge clk); sec_mark = 1'b0;
    ul = 0;
    for (int i = 0; i < 30; i++) begin
      if (uip || upd_done) ul++;
      @(negedge clk);
    end
    check("R9 no activity", 8'(ul), 8'd0);
    rd(4'd0, d); check("R9 sec held", d, 8'h11);
    wr(4'd11, 8'h02);

    // R10 alarm match and miss
    f = '{8'h29, 8'h20, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00};
    load(8'h02, f);
    wr(4'd1, 8'h30); wr(4'd3, 8'h20); wr(4'd5, 8'h10);
    second(di, ul, hit); check("R10 match", {7'b0, hit}, 8'h01);
    second(di, ul, hit); check("R10 miss", {7'b0, hit}, 8'h00);
    // R11 masks
    wr(4'd1, 8'hC0); wr(4'd3, 8'hC0); wr(4'd5, 8'hC0);
    second(di, ul, hit); check("R11 all masked", {7'b0, hit}, 8'h01);
    wr(4'd3, 8'h21);
    second(di, ul, hit); check("R11 min mismatch", {7'b0, hit}, 8'h00);
    wr(4'd3, 8'hC0); wr(4'd1, 8'h80);
    second(di, ul, hit); check("R11 single top bit", {7'b0, hit}, 8'h00);

    // R12 write lands in advance cycle
    f = '{8'h59, 8'h30, 8'h12, 8'h01, 8'h01, 8'h01, 8'h00};
    load(8'h02, f);
    @(negedge clk); sec_mark = 1'b1;
    @(negedge clk); sec_mark = 1'b0;
    repeat (7) @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1; req_addr = 4'd0; req_wdata = 8'h40;
    @(negedge clk);
    req_valid = 1'b0; req_we = 1'b0;
    check("R12 collide cycle", {7'b0, upd_done}, 8'h01);
    while (uip) @(negedge clk);
    rd(4'd0, d); check("R12 write wins", d, 8'h40);
    rd(4'd2, d); check("R12 carry kept", d, 8'h31);

    summary();
  end

endmodule